// File: doc/BRIEF.md
# UART Channel Mode Router

This block sits between the serial side of a UART (the receive and transmit shift registers) and its two byte queues. It decides, byte by byte, where data goes. A 2-bit channel mode selects one of four modes: normal, automatic echo, local loopback and remote loopback. The sources are a completed serial byte, a line break and a CPU write to the data register. The destinations are a push into the RX FIFO, a push into the TX FIFO, both of them, or neither. Every push is gated by the enable and disable bits of its direction.

The block does not store the queues. It reads their occupancy counts and asserts registered push strobes with their data. When a byte cannot be stored, it raises a one-cycle overflow event. It also serves CPU reads of the RX FIFO: it pops the head byte, or returns zero when the FIFO is empty. It produces a receive-ready flag for flow control towards the serial receiver.

The mode used for serial bytes is captured only while the receiver is idle. A mode change made during a frame therefore takes effect from the next whole byte.

Top module: `uart_chmode_router`

## Requirements
- R1: While reset is high and in the first cycle after it, all push, pop and overflow outputs are 0, the read data is 0 and the effective mode is normal (0).
- R2: A completed serial byte is pushed into the RX FIFO in mode 0 (normal) and mode 1 (echo), and into the TX FIFO in mode 3 (remote loopback) and mode 1. In mode 2 (local loopback) it goes nowhere. Each push appears on the outputs one cycle after the input.
- R3: A CPU data write goes to the TX FIFO in mode 0 and to the RX FIFO in mode 2. In modes 1 and 3 it is dropped without an overflow event. CPU writes follow the live mode input.
- R4: No RX push occurs unless rx_en=1 and rx_dis=0, and no TX push occurs unless tx_en=1 and tx_dis=0. A push that is blocked this way vanishes without an overflow event.
- R5: A byte whose enabled destination is full is discarded and ovf_evt pulses for one cycle. In echo mode, if either enabled destination is full, the byte is pushed to neither FIFO.
- R6: A FIFO counts as full when its occupancy count plus the push issued in the previous cycle reaches its depth. A pop in flight is not credited.
- R7: A break pushes 0x00 into the RX FIFO in every mode, subject to R4 and R5. A break in the same cycle as a completed serial byte is ignored.
- R8: When a serial byte or a break claims the same FIFO as a CPU write in the same cycle, the serial side wins. The CPU write is dropped and ovf_evt pulses.
- R9: rxs_ready is 1 exactly when every FIFO written by the effective mode is not full per R6. In mode 2 it is always 1.
- R10: The effective mode for serial bytes, breaks and readiness is loaded from mode_sel in every cycle where rxs_busy is 0, and holds while rxs_busy is 1.
- R11: A CPU read is honoured only when the RX direction is enabled. If the FIFO is non-empty, a read pops the FIFO and cpu_rdata carries its head on the next cycle. If the FIFO is empty, or no read is honoured, cpu_rdata is 0 and no pop occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Channel mode: 0 normal, 1 echo, 2 local loopback, 3 remote loopback |
| rx_en | input | 1 | Receive direction enable |
| rx_dis | input | 1 | Receive direction disable (overrides enable) |
| tx_en | input | 1 | Transmit direction enable |
| tx_dis | input | 1 | Transmit direction disable (overrides enable) |
| rxs_busy | input | 1 | Serial receiver is inside a frame |
| rxs_valid | input | 1 | Serial receiver completed a byte this cycle |
| rxs_data | input | DATA_W | Completed serial byte |
| rxs_break | input | 1 | Break condition detected on the line |
| cpu_wr | input | 1 | CPU write to the data register |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rd | input | 1 | CPU read of the data register |
| rxf_count | input | RX_CW | RX FIFO occupancy |
| txf_count | input | TX_CW | TX FIFO occupancy |
| rxf_head | input | DATA_W | RX FIFO head byte |
| rxf_push | output | 1 | Push strobe to the RX FIFO |
| rxf_data | output | DATA_W | Data for the RX FIFO push |
| txf_push | output | 1 | Push strobe to the TX FIFO |
| txf_data | output | DATA_W | Data for the TX FIFO push |
| rxf_pop | output | 1 | Pop strobe to the RX FIFO |
| cpu_rdata | output | DATA_W | Read data returned to the CPU |
| ovf_evt | output | 1 | One-cycle overflow event |
| rxs_ready | output | 1 | Flow control: the serial receiver may deliver a byte |

## Verification
The hardest case to reach is a full FIFO seen only through the push still in flight. The count shows one free slot, but the registered push from the previous cycle has already taken it. The bench gets there by sending serial bytes and CPU writes back to back, with draining switched off, until the queues overflow. A second hard case is a mode change during a frame while CPU writes follow the new mode. The bench holds rxs_busy high across a mode change and fires a serial byte and a CPU write at the same FIFO in one cycle. A long random phase then mixes modes, enables, breaks, reads and draining, and the behavioural model follows it cycle by cycle.

// File: rtl/uart_chm_pkg.sv
package uart_chm_pkg;
  typedef enum logic [1:0] {
    CHM_NORMAL = 2'd0,
    CHM_ECHO   = 2'd1,
    CHM_LOCAL  = 2'd2,
    CHM_REMOTE = 2'd3
  } chm_mode_e;

  // serial path writes the RX FIFO in this mode
  function automatic logic chm_writes_rx(input chm_mode_e m);
    return (m == CHM_NORMAL) || (m == CHM_ECHO);
  endfunction

  // serial path writes the TX FIFO in this mode
  function automatic logic chm_writes_tx(input chm_mode_e m);
    return (m == CHM_REMOTE) || (m == CHM_ECHO);
  endfunction
endpackage

// File: rtl/chm_mode_hold.sv
module chm_mode_hold
  import uart_chm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       busy,
  input  logic [1:0] mode_in,
  output chm_mode_e  mode_q
);
  always_ff @(posedge clk) begin
    if (rst) mode_q <= CHM_NORMAL;
    else if (!busy) mode_q <= chm_mode_e'(mode_in);
  end

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(mode_q));
endmodule

// File: rtl/chm_space.sv
module chm_space #(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] count,
  input  logic          pend,
  output logic [CW:0]   occ,
  output logic          full
);
  localparam logic [CW:0] DEPTH_V = (CW+1)'(DEPTH);

  always_comb begin
    occ  = {1'b0, count} + {{CW{1'b0}}, pend};
    full = (occ >= DEPTH_V);
  end
endmodule

// File: rtl/chm_route.sv
module chm_route
  import uart_chm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  chm_mode_e          eff_mode,
  input  logic [1:0]         live_mode,
  input  logic               rx_ok,
  input  logic               tx_ok,
  input  logic               rx_full,
  input  logic               tx_full,
  input  logic               s_valid,
  input  logic [DATA_W-1:0]  s_data,
  input  logic               s_break,
  input  logic               c_wr,
  input  logic [DATA_W-1:0]  c_data,
  output logic               rx_push_d,
  output logic [DATA_W-1:0]  rx_data_d,
  output logic               tx_push_d,
  output logic [DATA_W-1:0]  tx_data_d,
  output logic               ovf_d
);
  logic ser_rx, ser_tx, ser_block, brk_rx, claim_rx, cpu_rx, cpu_tx;

  always_comb begin
    ser_rx    = s_valid && chm_writes_rx(eff_mode) && rx_ok;
    ser_tx    = s_valid && chm_writes_tx(eff_mode) && tx_ok;
    ser_block = (ser_rx && rx_full) || (ser_tx && tx_full);
    brk_rx    = !s_valid && s_break && rx_ok;
    claim_rx  = ser_rx || brk_rx;
    cpu_rx    = c_wr && (live_mode == 2'd2) && rx_ok;
    cpu_tx    = c_wr && (live_mode == 2'd0) && tx_ok;

    rx_push_d = (ser_rx && !ser_block) || (brk_rx && !rx_full) ||
                (cpu_rx && !claim_rx && !rx_full);
    if (ser_rx)      rx_data_d = s_data;
    else if (brk_rx) rx_data_d = '0;
    else             rx_data_d = c_data;

    tx_push_d = (ser_tx && !ser_block) || (cpu_tx && !ser_tx && !tx_full);
    tx_data_d = ser_tx ? s_data : c_data;

    ovf_d = ser_block || (brk_rx && rx_full) ||
            (cpu_rx && (claim_rx || rx_full)) ||
            (cpu_tx && (ser_tx || tx_full));
  end
endmodule

// File: rtl/uart_chmode_router.sv
module uart_chmode_router
  import uart_chm_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int RX_DEPTH = 64,
  parameter int TX_DEPTH = 64,
  localparam int RX_CW   = $clog2(RX_DEPTH + 1),
  localparam int TX_CW   = $clog2(TX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode_sel,
  input  logic              rx_en,
  input  logic              rx_dis,
  input  logic              tx_en,
  input  logic              tx_dis,
  input  logic              rxs_busy,
  input  logic              rxs_valid,
  input  logic [DATA_W-1:0] rxs_data,
  input  logic              rxs_break,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd,
  input  logic [RX_CW-1:0]  rxf_count,
  input  logic [TX_CW-1:0]  txf_count,
  input  logic [DATA_W-1:0] rxf_head,
  output logic              rxf_push,
  output logic [DATA_W-1:0] rxf_data,
  output logic              txf_push,
  output logic [DATA_W-1:0] txf_data,
  output logic              rxf_pop,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              ovf_evt,
  output logic              rxs_ready
);
  chm_mode_e          eff_mode;
  logic               rx_ok, tx_ok, rx_full, tx_full;
  logic [RX_CW:0]     rx_occ;
  logic [TX_CW:0]     tx_occ;
  logic               rx_push_d, tx_push_d, ovf_d, rd_take;
  logic [DATA_W-1:0]  rx_data_d, tx_data_d;

  assign rx_ok = rx_en && !rx_dis;
  assign tx_ok = tx_en && !tx_dis;

  chm_mode_hold u_hold (
    .clk(clk), .rst(rst), .busy(rxs_busy), .mode_in(mode_sel), .mode_q(eff_mode)
  );

  chm_space #(.DEPTH(RX_DEPTH), .CW(RX_CW)) u_rx_space (
    .count(rxf_count), .pend(rxf_push), .occ(rx_occ), .full(rx_full)
  );

  chm_space #(.DEPTH(TX_DEPTH), .CW(TX_CW)) u_tx_space (
    .count(txf_count), .pend(txf_push), .occ(tx_occ), .full(tx_full)
  );

  chm_route #(.DATA_W(DATA_W)) u_route (
    .eff_mode(eff_mode), .live_mode(mode_sel), .rx_ok(rx_ok), .tx_ok(tx_ok),
    .rx_full(rx_full), .tx_full(tx_full), .s_valid(rxs_valid), .s_data(rxs_data),
    .s_break(rxs_break), .c_wr(cpu_wr), .c_data(cpu_wdata),
    .rx_push_d(rx_push_d), .rx_data_d(rx_data_d),
    .tx_push_d(tx_push_d), .tx_data_d(tx_data_d), .ovf_d(ovf_d)
  );

  assign rd_take = cpu_rd && rx_ok && (rxf_count != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rxf_push  <= 1'b0;
      rxf_data  <= '0;
      txf_push  <= 1'b0;
      txf_data  <= '0;
      rxf_pop   <= 1'b0;
      cpu_rdata <= '0;
      ovf_evt   <= 1'b0;
    end else begin
      rxf_push  <= rx_push_d;
      rxf_data  <= rx_data_d;
      txf_push  <= tx_push_d;
      txf_data  <= tx_data_d;
      rxf_pop   <= rd_take;
      cpu_rdata <= rd_take ? rxf_head : '0;
      ovf_evt   <= ovf_d;
    end
  end

  assign rxs_ready = (!chm_writes_rx(eff_mode) || !rx_full) &&
                     (!chm_writes_tx(eff_mode) || !tx_full);

  // R4
  rx_gate_chk: assert property (@(posedge clk) disable iff (rst)
    rxf_push |-> $past(rx_en && !rx_dis));

  // R4
  tx_gate_chk: assert property (@(posedge clk) disable iff (rst)
    txf_push |-> $past(tx_en && !tx_dis));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    rxf_push |-> ($past(rx_occ) < (RX_CW+1)'(RX_DEPTH)));

  // R6
  no_tx_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    txf_push |-> ($past(tx_occ) < (TX_CW+1)'(TX_DEPTH)));

  // R11
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rxf_count) == '0) |-> (cpu_rdata == '0 && !rxf_pop));
endmodule

// File: tb/test_uart_chmode_router.sv
module test_uart_chmode_router;
  localparam int DW = 8;
  localparam int RXD = 16;
  localparam int TXD = 16;
  localparam int RXCW = $clog2(RXD + 1);
  localparam int TXCW = $clog2(TXD + 1);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic [1:0] mode_sel = '0;
  logic rx_en = 0, rx_dis = 0, tx_en = 0, tx_dis = 0;
  logic rxs_busy = 0, rxs_valid = 0, rxs_break = 0, cpu_wr = 0, cpu_rd = 0;
  logic [DW-1:0] rxs_data = '0, cpu_wdata = '0;
  logic [RXCW-1:0] rxc = '0;
  logic [TXCW-1:0] txc = '0;
  logic [DW-1:0] head = '0;
  logic drain_on = 0;

  logic rxf_push, txf_push, rxf_pop, ovf_evt, rxs_ready;
  logic [DW-1:0] rxf_data, txf_data, cpu_rdata;

  uart_chmode_router #(.DATA_W(DW), .RX_DEPTH(RXD), .TX_DEPTH(TXD)) i_uart_chmode_router (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .rx_en(rx_en), .rx_dis(rx_dis),
    .tx_en(tx_en), .tx_dis(tx_dis), .rxs_busy(rxs_busy), .rxs_valid(rxs_valid),
    .rxs_data(rxs_data), .rxs_break(rxs_break), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .rxf_count(rxc), .txf_count(txc), .rxf_head(head),
    .rxf_push(rxf_push), .rxf_data(rxf_data), .txf_push(txf_push), .txf_data(txf_data),
    .rxf_pop(rxf_pop), .cpu_rdata(cpu_rdata), .ovf_evt(ovf_evt), .rxs_ready(rxs_ready)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // reference model state
  int m_eff = 0;
  bit m_rxp = 0, m_txp = 0;
  bit e_rxp = 0, e_txp = 0, e_pop = 0, e_ovf = 0;
  logic [DW-1:0] e_rxd = '0, e_txd = '0, e_rdat = '0;
  string t_rx = "R2", t_tx = "R2", t_ovf = "R5";
  bit in_rst_prev = 1;
  byte unsigned rq[$];
  byte unsigned tq[$];

  task automatic chk(input string req, input string nm, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, nm, act, exp, $time);
    end
  endtask

  // model + FIFO environment, one process so the order is fixed
  always @(posedge clk) begin
    bit rx_ok, tx_ok, rx_full, tx_full, s_rx, s_tx, b_rx;
    bit n_rxp, n_txp, n_ovf, n_pop;
    logic [DW-1:0] n_rxd, n_txd, n_rd;
    in_rst_prev = rst;
    if (rst) begin
      m_eff = 0; m_rxp = 0; m_txp = 0;
      e_rxp = 0; e_txp = 0; e_pop = 0; e_ovf = 0; e_rdat = '0;
    end else begin
      rx_ok = rx_en && !rx_dis;
      tx_ok = tx_en && !tx_dis;
      rx_full = (int'(rxc) + int'(m_rxp)) >= RXD;
      tx_full = (int'(txc) + int'(m_txp)) >= TXD;
      n_rxp = 0; n_txp = 0; n_ovf = 0; n_pop = 0;
      n_rxd = e_rxd; n_txd = e_txd; n_rd = '0;
      t_rx = "R2"; t_tx = "R2"; t_ovf = "R5";
      s_rx = rxs_valid && (m_eff == 0 || m_eff == 1) && rx_ok;
      s_tx = rxs_valid && (m_eff == 1 || m_eff == 3) && tx_ok;
      b_rx = !rxs_valid && rxs_break && rx_ok;
      if (rxs_valid && !(rx_ok && tx_ok)) begin t_rx = "R4"; t_tx = "R4"; end
      if (rxs_valid && m_eff != int'(mode_sel)) begin t_rx = "R10"; t_tx = "R10"; end
      if (rxs_valid) begin
        if ((s_rx && rx_full) || (s_tx && tx_full)) begin
          n_ovf = 1;
          if (int'(rxc) < RXD && int'(txc) < TXD) t_ovf = "R6";
        end else begin
          if (s_rx) begin n_rxp = 1; n_rxd = rxs_data; end
          if (s_tx) begin n_txp = 1; n_txd = rxs_data; end
        end
      end else if (b_rx) begin
        t_rx = "R7";
        if (rx_full) begin n_ovf = 1; t_ovf = "R7"; end
        else begin n_rxp = 1; n_rxd = '0; end
      end
      if (cpu_wr && mode_sel == 2'd2 && rx_ok) begin
        if (s_rx || b_rx) begin n_ovf = 1; t_ovf = "R8"; end
        else if (rx_full) n_ovf = 1;
        else begin n_rxp = 1; n_rxd = cpu_wdata; t_rx = "R3"; end
      end
      if (cpu_wr && mode_sel == 2'd0 && tx_ok) begin
        if (s_tx) begin n_ovf = 1; t_ovf = "R8"; end
        else if (tx_full) n_ovf = 1;
        else begin n_txp = 1; n_txd = cpu_wdata; t_tx = "R3"; end
      end
      if (cpu_rd && rx_ok && rxc != '0) begin n_pop = 1; n_rd = head; end
      e_rxp = n_rxp; e_txp = n_txp; e_ovf = n_ovf; e_pop = n_pop;
      e_rxd = n_rxd; e_txd = n_txd; e_rdat = n_rd;
      m_rxp = n_rxp; m_txp = n_txp;
      if (!rxs_busy) m_eff = int'(mode_sel);
    end
    // FIFO environment, driven by the DUT's strobes
    if (rst) begin
      rq.delete(); tq.delete();
    end else begin
      if (rxf_push) rq.push_back(rxf_data);
      if (rxf_pop && rq.size() > 0) void'(rq.pop_front());
      if (txf_push) tq.push_back(txf_data);
      if (drain_on && tq.size() > 0 && ($urandom % 3) == 0) void'(tq.pop_front());
    end
    rxc  <= RXCW'(rq.size());
    txc  <= TXCW'(tq.size());
    head <= (rq.size() > 0) ? rq[0] : '0;
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    bit rf, tf, er;
    if (rst || in_rst_prev) begin
      if (total < 200 || !rst) begin
        chk("R1", "rxf_push", rxf_push, 0);
        chk("R1", "txf_push", txf_push, 0);
        chk("R1", "rxf_pop", rxf_pop, 0);
        chk("R1", "ovf_evt", ovf_evt, 0);
        chk("R1", "cpu_rdata", cpu_rdata, 0);
      end
    end else begin
      chk(t_rx, "rxf_push", rxf_push, e_rxp);
      if (e_rxp) chk(t_rx, "rxf_data", rxf_data, e_rxd);
      chk(t_tx, "txf_push", txf_push, e_txp);
      if (e_txp) chk(t_tx, "txf_data", txf_data, e_txd);
      chk(t_ovf, "ovf_evt", ovf_evt, e_ovf);
      chk("R11", "rxf_pop", rxf_pop, e_pop);
      chk("R11", "cpu_rdata", cpu_rdata, e_rdat);
      rf = (int'(rxc) + int'(m_rxp)) >= RXD;
      tf = (int'(txc) + int'(m_txp)) >= TXD;
      er = (!(m_eff == 0 || m_eff == 1) || !rf) && (!(m_eff == 1 || m_eff == 3) || !tf);
      chk("R9", "rxs_ready", rxs_ready, er);
    end
  end

  task automatic idle();
    rxs_valid = 0; rxs_break = 0; cpu_wr = 0; cpu_rd = 0;
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
    idle();
  endtask

  task automatic ser(input byte unsigned d);
    rxs_valid = 1; rxs_data = d; @(negedge clk); idle();
  endtask

  task automatic cwr(input byte unsigned d);
    cpu_wr = 1; cpu_wdata = d; @(negedge clk); idle();
  endtask

  task automatic crd();
    cpu_rd = 1; @(negedge clk); idle(); @(negedge clk);
  endtask

  initial begin
    rst = 1;
    tick(4);
    rst = 0;
    tick(2);
    rx_en = 1; tx_en = 1; drain_on = 0;
    // R2 / R3 / R7 in each mode
    for (int m = 0; m < 4; m++) begin
      mode_sel = 2'(m); tick(2);
      ser(8'h10 + 8'(m)); tick(1);
      cwr(8'h20 + 8'(m)); tick(1);
      rxs_break = 1; tick(1); tick(1);
      rxs_break = 1; rxs_valid = 1; rxs_data = 8'h5A; tick(1); tick(1);
    end
    // R4 gating
    mode_sel = 2'd1; tick(2);
    rx_dis = 1; ser(8'h31); cwr(8'h32); crd();
    rx_dis = 0; tx_dis = 1; ser(8'h33); tx_dis = 0; tx_en = 0;
    mode_sel = 2'd0; tick(1); cwr(8'h34); tx_en = 1; tick(2);
    // drain the queues through reads and the environment
    drain_on = 1;
    for (int i = 0; i < 20; i++) crd();
    drain_on = 0; tick(2);
    // R5 / R6 fill RX back to back, then overflow
    for (int i = 0; i < RXD + 3; i++) begin rxs_valid = 1; rxs_data = 8'(i); tick(1); end
    tick(2);
    mode_sel = 2'd1; tick(2); ser(8'hEE); tick(1);
    // fill TX with CPU writes back to back
    mode_sel = 2'd0; tick(2);
    for (int i = 0; i < TXD + 3; i++) begin cpu_wr = 1; cpu_wdata = 8'h80 + 8'(i); tick(1); end
    tick(2);
    mode_sel = 2'd3; tick(2); ser(8'hDD);
    // R11 read out everything, then read empty
    drain_on = 1;
    for (int i = 0; i < RXD + 4; i++) crd();
    tick(20);
    // R8 conflicts: break vs CPU write in local loopback
    mode_sel = 2'd2; tick(2);
    rxs_break = 1; cpu_wr = 1; cpu_wdata = 8'h44; tick(1); tick(1);
    // R10 mode held during a frame, CPU follows live mode
    mode_sel = 2'd0; tick(2);
    rxs_busy = 1; mode_sel = 2'd2; tick(2);
    rxs_valid = 1; rxs_data = 8'h66; cpu_wr = 1; cpu_wdata = 8'h77; tick(1);
    mode_sel = 2'd0; rxs_valid = 1; rxs_data = 8'h67; tick(1);
    mode_sel = 2'd3; tick(1);
    rxs_valid = 1; rxs_data = 8'h68; tick(1);
    rxs_busy = 0; tick(2); ser(8'h69); tick(2);
    mode_sel = 2'd0; tick(2);
    rxs_busy = 1; mode_sel = 2'd3; tick(1);
    rxs_valid = 1; rxs_data = 8'h6A; cpu_wr = 1; cpu_wdata = 8'h6B; tick(1);
    rxs_busy = 0; tick(4);
    // random phase
    for (int i = 0; i < 6000; i++) begin
      if (($urandom % 40) == 0) mode_sel = 2'($urandom);
      if (($urandom % 60) == 0) begin
        rx_en = ($urandom % 8) != 0; rx_dis = ($urandom % 8) == 0;
        tx_en = ($urandom % 8) != 0; tx_dis = ($urandom % 8) == 0;
      end
      rxs_busy  = ($urandom % 4) == 0;
      rxs_valid = ($urandom % 3) == 0;
      rxs_data  = 8'($urandom);
      rxs_break = ($urandom % 25) == 0;
      cpu_wr    = ($urandom % 3) == 0;
      cpu_wdata = 8'($urandom);
      cpu_rd    = ($urandom % 3) == 0;
      drain_on  = (i % 700) > 200;
      @(negedge clk);
    end
    idle(); tick(4);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule